// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block arbitrates the interrupt sources of a 16550-style serial port. Five causes compete: receive line errors, a character timeout, received data, an empty transmit holding register, and a change on the modem status lines. The block applies a fixed priority to them and produces one interrupt request line and the identification byte that software reads to learn which cause is being reported. The FIFOs, the shift registers, the baud generator and the modem status logic sit outside the block, and their state arrives on input pins.

The block holds the four-bit interrupt enable register. It also holds the one internal flag that cannot be derived from its inputs: the flag that says a transmit-empty interrupt is pending. A register access updates this flag. A write to the transmit holding register or a read of the identification byte while it shows the transmit-empty code clears the flag. Toggling the transmit-empty enable bit re-arms the flag when the holding register is already empty. The transmit holding register going empty also sets the flag.

Top module: `uart_irq_ident`

## Requirements
- R1: When several causes are active, the identification code reports only the highest one. The order from highest to lowest is line error (0x06), character timeout (0x0C), received data (0x04), transmit empty (0x02) and modem change (0x00). With no active cause the code is 0x01.
- R2: The line error cause is active when enable bit 2 is set and at least one of the four error flags (overrun, parity, framing, break) is set.
- R3: The character timeout cause is active when enable bit 0 is set and the timeout-pending input is high. Enable bit 0 is its only enable, so the timeout input has no effect while enable bit 0 is clear.
- R4: The received data cause needs enable bit 0 and data-ready. With the FIFOs enabled, the receive count must also be at least the trigger level. With the FIFOs disabled, data-ready alone is enough.
- R5: The transmit empty cause is active when enable bit 1 is set and the internal transmit-empty pending flag is set.
- R6: The modem change cause is active when enable bit 3 is set and any of the four modem delta bits is set.
- R7: Each of the following clears the transmit-empty pending flag: a read of the identification byte while its code is 0x02, or a write to the transmit holding register. An identification read while the code shows anything else leaves the flag unchanged.
- R8: A write that changes enable bit 1 sets the pending flag if the new bit is 1 and the holding register is empty. Any other change of enable bit 1 clears the flag. This rule takes precedence over all other updates of the flag in the same cycle.
- R9: A rising edge on the holding-register-empty input sets the pending flag, unless a rule in R7 or R8 acts in the same cycle.
- R10: An enable write stores only data bits 3:0. The enable readback returns the stored bits in 3:0 and zeros in 7:4.
- R11: Identification bits 7:6 read 11 while the FIFOs are enabled and 00 otherwise. Bits 5:4 always read 0. Bits 3:0 carry the code.
- R12: The identification byte and the request line are registered. Both reflect the inputs and stored state of the previous cycle. The request line is high exactly when the code differs from 0x01.
- R13: A synchronous reset clears the enable register and the pending flag. After reset the identification byte reads 0x01 and the request line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_wr_en | input | 1 | Write strobe for the interrupt enable register |
| ier_wr_data | input | 8 | Data written to the enable register |
| thr_wr | input | 1 | Write strobe of the transmit holding register |
| iir_rd | input | 1 | Read strobe of the identification byte |
| fifo_en | input | 1 | FIFOs enabled |
| lsr_err | input | 4 | Error flags: overrun, parity, framing, break |
| data_ready | input | 1 | Receive data ready |
| rx_count | input | CNT_W | Receive FIFO fill level |
| rx_trigger | input | CNT_W | Receive FIFO trigger level |
| timeout_pend | input | 1 | Character timeout pending |
| thr_empty | input | 1 | Transmit holding register empty |
| msr_delta | input | 4 | Modem status delta bits |
| ier_rd | output | 8 | Enable register readback |
| iir_q | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The transmit-empty pending flag is the hardest state to reach, because no port shows it directly. The stimulus makes it visible by enabling only the transmit-empty cause, so that the identification code shows whether the flag is set. It sets and clears the flag through enable toggles, holding-register writes, identification reads and rising edges of the empty input. One case masks the flag behind a line error while an identification read happens. The bench then removes the error, and the transmit-empty code must come back, which shows that the read did not clear the flag.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_CAUSES = 5;

    typedef enum logic [3:0] {
        ID_MODEM   = 4'h0,
        ID_NONE    = 4'h1,
        ID_THRE    = 4'h2,
        ID_RXDATA  = 4'h4,
        ID_LINE    = 4'h6,
        ID_TIMEOUT = 4'hC
    } irq_id_e;

    // Rank 0 is the highest priority.
    function automatic irq_id_e id_of_rank(input int rank);
        case (rank)
            0:       return ID_LINE;
            1:       return ID_TIMEOUT;
            2:       return ID_RXDATA;
            3:       return ID_THRE;
            default: return ID_MODEM;
        endcase
    endfunction

    function automatic logic [7:0] ident_byte(input logic fifo_on, input irq_id_e id);
        return {{2{fifo_on}}, 2'b00, id};
    endfunction

endpackage

// File: rtl/uart_irq_enable.sv
module uart_irq_enable
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ier_wr_en,
    input  logic [7:0] ier_wr_data,
    input  logic       thr_wr,
    input  logic       iir_rd,
    input  logic [3:0] shown_id,
    input  logic       thr_empty,
    output logic [3:0] ier_q,
    output logic       thre_pend
);

    logic thr_empty_q;
    logic bit1_change;
    logic empty_rise;

    assign bit1_change = ier_wr_en && (ier_wr_data[1] != ier_q[1]);
    assign empty_rise  = thr_empty && !thr_empty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ier_q       <= '0;
            thre_pend   <= 1'b0;
            thr_empty_q <= 1'b1;
        end else begin
            thr_empty_q <= thr_empty;
            if (ier_wr_en) begin
                ier_q <= ier_wr_data[3:0];
            end
            if (bit1_change) begin
                thre_pend <= ier_wr_data[1] && thr_empty;
            end else if (thr_wr) begin
                thre_pend <= 1'b0;
            end else if (iir_rd && shown_id == ID_THRE) begin
                thre_pend <= 1'b0;
            end else if (empty_rise) begin
                thre_pend <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/uart_irq_causes.sv
module uart_irq_causes
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [3:0]            ier_q,
    input  logic                  fifo_en,
    input  logic [3:0]            lsr_err,
    input  logic                  data_ready,
    input  logic [CNT_W-1:0]      rx_count,
    input  logic [CNT_W-1:0]      rx_trigger,
    input  logic                  timeout_pend,
    input  logic                  thre_pend,
    input  logic [3:0]            msr_delta,
    output logic [NUM_CAUSES-1:0] req_by_rank
);

    logic fill_ok;

    assign fill_ok = !fifo_en || (rx_count >= rx_trigger);

    always_comb begin
        req_by_rank    = '0;
        req_by_rank[0] = ier_q[2] && (|lsr_err);
        req_by_rank[1] = ier_q[0] && timeout_pend;
        req_by_rank[2] = ier_q[0] && data_ready && fill_ok;
        req_by_rank[3] = ier_q[1] && thre_pend;
        req_by_rank[4] = ier_q[3] && (|msr_delta);
    end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [NUM_CAUSES-1:0] req_by_rank,
    output irq_id_e               id
);

    logic [NUM_CAUSES-1:0] grant;

    generate
        for (genvar r = 0; r < NUM_CAUSES; r++) begin : g_rank
            if (r == 0) begin : g_top
                assign grant[r] = req_by_rank[r];
            end else begin : g_lower
                assign grant[r] = req_by_rank[r] && !(|req_by_rank[r-1:0]);
            end
        end
    endgenerate

    always_comb begin
        id = ID_NONE;
        for (int r = 0; r < NUM_CAUSES; r++) begin
            if (grant[r]) begin
                id = id_of_rank(r);
            end
        end
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ier_wr_en,
    input  logic [7:0]       ier_wr_data,
    input  logic             thr_wr,
    input  logic             iir_rd,
    input  logic             fifo_en,
    input  logic [3:0]       lsr_err,
    input  logic             data_ready,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trigger,
    input  logic             timeout_pend,
    input  logic             thr_empty,
    input  logic [3:0]       msr_delta,
    output logic [7:0]       ier_rd,
    output logic [7:0]       iir_q,
    output logic             irq
);

    logic [3:0]            ier_q;
    logic                  thre_pend;
    logic [NUM_CAUSES-1:0] req_by_rank;
    irq_id_e               win_id;

    uart_irq_enable u_enable (
        .clk         (clk),
        .rst         (rst),
        .ier_wr_en   (ier_wr_en),
        .ier_wr_data (ier_wr_data),
        .thr_wr      (thr_wr),
        .iir_rd      (iir_rd),
        .shown_id    (iir_q[3:0]),
        .thr_empty   (thr_empty),
        .ier_q       (ier_q),
        .thre_pend   (thre_pend)
    );

    uart_irq_causes #(.CNT_W(CNT_W)) u_causes (
        .ier_q        (ier_q),
        .fifo_en      (fifo_en),
        .lsr_err      (lsr_err),
        .data_ready   (data_ready),
        .rx_count     (rx_count),
        .rx_trigger   (rx_trigger),
        .timeout_pend (timeout_pend),
        .thre_pend    (thre_pend),
        .msr_delta    (msr_delta),
        .req_by_rank  (req_by_rank)
    );

    uart_irq_prio u_prio (
        .req_by_rank (req_by_rank),
        .id          (win_id)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            iir_q <= ident_byte(1'b0, ID_NONE);
            irq   <= 1'b0;
        end else begin
            iir_q <= ident_byte(fifo_en, win_id);
            irq   <= (win_id != ID_NONE);
        end
    end

    assign ier_rd = {4'b0000, ier_q};

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             ier_wr_en,
    input logic [7:0]       ier_wr_data,
    input logic             thr_wr,
    input logic             fifo_en,
    input logic [3:0]       lsr_err,
    input logic             timeout_pend,
    input logic [7:0]       ier_rd,
    input logic [7:0]       iir_q,
    input logic             irq,
    input logic             thre_pend
);

    assert_line_wins_R2: assert property (@(posedge clk) disable iff (rst)
        (ier_rd[2] && (|lsr_err)) |=> (iir_q[3:0] == 4'h6 && irq));

    assert_timeout_second_R3: assert property (@(posedge clk) disable iff (rst)
        (!(ier_rd[2] && (|lsr_err)) && ier_rd[0] && timeout_pend) |=> (iir_q[3:0] == 4'hC));

    assert_rx_masked_R3: assert property (@(posedge clk) disable iff (rst)
        (!ier_rd[0]) |=> (iir_q[3:0] != 4'hC && iir_q[3:0] != 4'h4));

    assert_thr_write_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (thr_wr && !(ier_wr_en && ier_wr_data[1] != ier_rd[1])) |=> !thre_pend);

    assert_ier_low_bits_R10: assert property (@(posedge clk) disable iff (rst)
        ier_wr_en |=> (ier_rd == {4'b0000, $past(ier_wr_data[3:0])}));

    assert_fifo_flag_bits_R11: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (iir_q[7:6] == {2{$past(fifo_en)}} && iir_q[5:4] == 2'b00));

    assert_irq_matches_code_R12: assert property (@(posedge clk) disable iff (rst)
        irq == (iir_q[3:0] != 4'h1));

endmodule

bind uart_irq_ident uart_irq_ident_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ier_wr_en    (ier_wr_en),
    .ier_wr_data  (ier_wr_data),
    .thr_wr       (thr_wr),
    .fifo_en      (fifo_en),
    .lsr_err      (lsr_err),
    .timeout_pend (timeout_pend),
    .ier_rd       (ier_rd),
    .iir_q        (iir_q),
    .irq          (irq),
    .thre_pend    (thre_pend)
);

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;

    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst;
    logic             ier_wr_en;
    logic [7:0]       ier_wr_data;
    logic             thr_wr;
    logic             iir_rd;
    logic             fifo_en;
    logic [3:0]       lsr_err;
    logic             data_ready;
    logic [CNT_W-1:0] rx_count;
    logic [CNT_W-1:0] rx_trigger;
    logic             timeout_pend;
    logic             thr_empty;
    logic [3:0]       msr_delta;
    logic [7:0]       ier_rd;
    logic [7:0]       iir_q;
    logic             irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    uart_irq_ident #(.CNT_W(CNT_W)) u_uart_irq_ident (
        .clk(clk), .rst(rst), .ier_wr_en(ier_wr_en), .ier_wr_data(ier_wr_data),
        .thr_wr(thr_wr), .iir_rd(iir_rd), .fifo_en(fifo_en), .lsr_err(lsr_err),
        .data_ready(data_ready), .rx_count(rx_count), .rx_trigger(rx_trigger),
        .timeout_pend(timeout_pend), .thr_empty(thr_empty), .msr_delta(msr_delta),
        .ier_rd(ier_rd), .iir_q(iir_q), .irq(irq)
    );

    typedef struct packed {
        logic [3:0] ier;
        logic       fifo;
        logic [3:0] lsr;
        logic       dr;
        logic [4:0] cnt;
        logic [4:0] trg;
        logic       tmo;
        logic [3:0] msd;
        logic [7:0] exp_iir;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{4'h0, 1'b0, 4'hF, 1'b1, 5'd9, 5'd1, 1'b1, 4'hF, 8'h01}, // R1 nothing enabled
        '{4'hD, 1'b1, 4'h1, 1'b1, 5'd9, 5'd1, 1'b1, 4'hF, 8'hC6}, // R2 overrun wins
        '{4'hD, 1'b1, 4'h0, 1'b1, 5'd9, 5'd1, 1'b1, 4'hF, 8'hCC}, // R1 timeout next
        '{4'h4, 1'b0, 4'h8, 1'b0, 5'd0, 5'd1, 1'b1, 4'h0, 8'h06}, // R2 break flag
        '{4'hC, 1'b0, 4'h0, 1'b1, 5'd0, 5'd1, 1'b1, 4'h1, 8'h00}, // R3 timeout masked
        '{4'h1, 1'b1, 4'h0, 1'b1, 5'd3, 5'd4, 1'b0, 4'h0, 8'hC1}, // R4 below trigger
        '{4'h1, 1'b1, 4'h0, 1'b1, 5'd4, 5'd4, 1'b0, 4'h0, 8'hC4}, // R4 at trigger
        '{4'h1, 1'b0, 4'h0, 1'b1, 5'd0, 5'd8, 1'b0, 4'h0, 8'h04}, // R4 non-FIFO
        '{4'h1, 1'b0, 4'h0, 1'b0, 5'd0, 5'd8, 1'b1, 4'h0, 8'h0C}, // R3 timeout alone
        '{4'h8, 1'b0, 4'h0, 1'b0, 5'd0, 5'd1, 1'b0, 4'h4, 8'h00}, // R6 modem delta
        '{4'h8, 1'b1, 4'h0, 1'b0, 5'd0, 5'd1, 1'b0, 4'h0, 8'hC1}, // R6 no delta, R11
        '{4'h9, 1'b0, 4'h0, 1'b1, 5'd0, 5'd1, 1'b0, 4'h2, 8'h04}  // R1 data over modem
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic check_id(input string req, input logic [7:0] exp);
        check8(req, iir_q, exp);
        check8({req, " irq"}, {7'd0, irq}, {7'd0, exp[3:0] != 4'h1});
    endtask

    task automatic write_ier(input logic [7:0] v);
        @(negedge clk);
        ier_wr_en   = 1'b1;
        ier_wr_data = v;
        @(negedge clk);
        ier_wr_en   = 1'b0;
    endtask

    task automatic pulse_thr_wr();
        @(negedge clk);
        thr_wr = 1'b1;
        @(negedge clk);
        thr_wr = 1'b0;
    endtask

    task automatic pulse_iir_rd();
        @(negedge clk);
        iir_rd = 1'b1;
        @(negedge clk);
        iir_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; ier_wr_en = 0; ier_wr_data = 0; thr_wr = 0; iir_rd = 0;
        fifo_en = 0; lsr_err = 0; data_ready = 0; rx_count = 0; rx_trigger = 0;
        timeout_pend = 0; thr_empty = 1'b1; msr_delta = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        check_id("R13 reset iir", 8'h01);
        check8("R13 reset ier", ier_rd, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            ier_wr_en    = 1'b1;
            ier_wr_data  = {4'h0, VECS[i].ier};
            fifo_en      = VECS[i].fifo;
            lsr_err      = VECS[i].lsr;
            data_ready   = VECS[i].dr;
            rx_count     = VECS[i].cnt;
            rx_trigger   = VECS[i].trg;
            timeout_pend = VECS[i].tmo;
            msr_delta    = VECS[i].msd;
            @(negedge clk);
            ier_wr_en = 1'b0;
            @(negedge clk);
            check_id($sformatf("R1 table row %0d", i), VECS[i].exp_iir);
        end

        fifo_en = 0; lsr_err = 0; data_ready = 0; timeout_pend = 0; msr_delta = 0;

        // R10 upper enable bits not stored
        thr_empty = 1'b0;
        write_ier(8'hF0);
        check8("R10 upper bits dropped", ier_rd, 8'h00);
        write_ier(8'h00);

        // R8 set pending on enable toggle with holding register empty; R5 code
        thr_empty = 1'b1;
        @(negedge clk);
        write_ier(8'h02);
        @(negedge clk);
        check_id("R8 R5 rearm on enable", 8'h02);

        // R7 identification read while showing 0x02 clears
        pulse_iir_rd();
        @(negedge clk);
        check_id("R7 read clears pending", 8'h01);

        // R8 re-arm by toggling the enable off and on
        write_ier(8'h00);
        write_ier(8'h02);
        @(negedge clk);
        check_id("R8 toggle rearm", 8'h02);

        // R7 holding register write clears
        pulse_thr_wr();
        @(negedge clk);
        check_id("R7 write clears pending", 8'h01);

        // R8 enable with holding register not empty leaves flag clear
        write_ier(8'h00);
        thr_empty = 1'b0;
        write_ier(8'h02);
        @(negedge clk);
        check_id("R8 no rearm when busy", 8'h01);

        // R9 rising empty edge sets pending
        @(negedge clk);
        thr_empty = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_id("R9 empty edge sets", 8'h02);

        // R1 line error masks transmit empty; R7 read of other code keeps flag
        write_ier(8'h06);
        lsr_err = 4'h2;
        @(negedge clk);
        @(negedge clk);
        check_id("R1 line over thre", 8'h06);
        pulse_iir_rd();
        lsr_err = 4'h0;
        @(negedge clk);
        @(negedge clk);
        check_id("R7 other-code read keeps", 8'h02);

        // R12 one-cycle latency of request line
        pulse_thr_wr();
        @(negedge clk);
        write_ier(8'h04);
        @(negedge clk);
        lsr_err = 4'h4;
        check8("R12 irq before edge", {7'd0, irq}, 8'h00);
        @(negedge clk);
        check8("R12 irq after one edge", {7'd0, irq}, 8'h01);

        // R13 reset again clears everything
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        lsr_err = 4'h0;
        check_id("R13 second reset iir", 8'h01);
        check8("R13 second reset ier", ier_rd, 8'h00);

        finish_run();
    end

endmodule